// File: doc/BRIEF.md
# Configurable Video Row Delay Bank

This block holds the recent image rows that a two-dimensional window filter needs next to the incoming pixel. It has two independent groups of delay stages. The first group is fed from the live pixel bus `pix_a`. The second group is fed from `pix_b`, a second bus that carries either the previous field of interlaced video or the row stream of a neighbouring filter device. Each stage delays its input by exactly one programmed row length. Every stage of a group is fed from the stage before it, so tap k of a group shows the pixel from the same column k+1 rows earlier.

The storage is a fixed set of equal RAM banks. In the shallow mode, each stage joins two banks, so a group has half as many stages but each row can be twice as long. In the deep mode, each bank is its own stage. The first stage of the second group can be taken out of the path. In interlaced video this is done in one field only, so that previous-field data always lines up with the row above the current one. The stage is removed when the `bypass_in` pin is high. A configuration bit forces the same removal for tall windows and makes the pin irrelevant.

A small controller has three states. It starts in IDLE after reset. It moves IDLE→FILL on the first accepted pixel. It moves FILL→RUN when the last pixel of the last required row is accepted. It moves FILL→IDLE and RUN→IDLE on any change of length or depth mode. It holds one address counter that all banks share. Each bank reads the old pixel before it writes the new one at the same address.

Top module: `line_delay_bank`

## Requirements
- R1: After reset `rows_ready` is 0 and the controller is in IDLE.
- R2: In shallow mode (`cfg_deep`=0) the row length is `cfg_last`+1, up to MAX_LEN. Each group has BPG/2 stages. Tap index g*BPG+k (g=0 for `pix_a`, g=1 for `pix_b`) equals that group's input from (k+1) row lengths of accepted pixels earlier.
- R3: In deep mode (`cfg_deep`=1) each group has BPG stages. The row length is (`cfg_last` mod MAX_LEN/2)+1, which means the top bit of `cfg_last` is ignored.
- R4: In shallow mode the taps with k ≥ BPG/2 read zero. Only one bank of each joined pair is written per pixel.
- R5: While `bypass_in` is 1, tap BPG equals `pix_b` in the same cycle, and the next stage of that group is fed from that tap.
- R6: While `cfg_force_byp` is 1, the bypass of R5 applies whatever the value of `bypass_in`.
- R7: A cycle with `pix_valid`=0 writes nothing and leaves the address unchanged. The taps then still show the values for the next pixel.
- R8: `rows_ready` rises on the clock edge that accepts pixel number L*len since the last clear, where L is the stage count per group. It stays 0 before that edge.
- R9: A change of `cfg_deep` or `cfg_last` clears the fill count and returns the controller to IDLE. Any pixel offered in that same cycle is dropped.
- R10: The shared address steps by one per accepted pixel and wraps to 0 after reaching the effective last index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Pixel strobe; the pixel is accepted when this is high |
| pix_a | input | PIX_W | Live pixel, feeds group 0 |
| pix_b | input | PIX_W | Second-bus pixel, feeds group 1 |
| bypass_in | input | 1 | Removes the first stage of group 1 from the path |
| cfg_deep | input | 1 | 1 = deep mode (BPG stages per group), 0 = shallow mode |
| cfg_force_byp | input | 1 | Forces the group 1 bypass on |
| cfg_last | input | $clog2(MAX_LEN) | Row length minus one |
| taps | output | 2*BPG*PIX_W | Stage outputs, slot g*BPG+k |
| rows_ready | output | 1 | All stages of both groups have filled |

## Verification
The assertions assume that configuration changes are the only way counters are cleared. A configuration change is seen one cycle after the inputs move. They also assume `cfg_force_byp` and `bypass_in` only steer data and never touch the counters. The stimulus changes length and depth only with a settle cycle, except in one directed case that offers a pixel in the change cycle on purpose. Pixels, idle gaps and bypass toggles are random, drawn from a fixed seed. Lengths are chosen so that every segment stays well inside the bench history arrays.

// File: rtl/lb_pkg.sv
package lb_pkg;
    typedef enum logic [1:0] {
        LB_IDLE = 2'd0,
        LB_FILL = 2'd1,
        LB_RUN  = 2'd2
    } lb_state_t;
endpackage

// File: rtl/lb_bank.sv
module lb_bank #(
    parameter int W     = 8,
    parameter int DEPTH = 128,
    localparam int BW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [BW-1:0] addr,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout
);
    logic [W-1:0] mem [DEPTH];

    // old contents appear before the write lands at the edge
    assign dout = mem[addr];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= din;
    end
endmodule

// File: rtl/lb_ctrl.sv
module lb_ctrl
    import lb_pkg::*;
#(
    parameter int AW  = 8,
    parameter int BPG = 4,
    localparam int BW = AW - 1,
    localparam int WW = $clog2(BPG + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_valid,
    input  logic          cfg_deep,
    input  logic [AW-1:0] cfg_last,
    output logic [AW-1:0] addr,
    output logic          wr_en,
    output logic          rows_ready
);
    localparam logic [AW-1:0] LOW_MASK  = AW'((1 << BW) - 1);
    localparam logic [WW-1:0] NEED_DEEP = WW'(BPG);
    localparam logic [WW-1:0] NEED_HALF = WW'(BPG / 2);

    lb_state_t     state, state_nx;
    logic [AW:0]   cfg_q;
    logic          cfg_chg;
    logic [AW-1:0] eff_last;
    logic [WW-1:0] wraps, need;
    logic          at_end;

    assign cfg_chg  = {cfg_deep, cfg_last} != cfg_q;
    assign eff_last = cfg_deep ? (cfg_last & LOW_MASK) : cfg_last;
    assign need     = cfg_deep ? NEED_DEEP : NEED_HALF;
    assign at_end   = (addr == eff_last);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= LB_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            LB_IDLE: if (cfg_chg)        state_nx = LB_IDLE;
                     else if (pix_valid) state_nx = LB_FILL;
            LB_FILL: if (cfg_chg)        state_nx = LB_IDLE;
                     else if (pix_valid && at_end && wraps == need - 1'b1)
                                         state_nx = LB_RUN;
            LB_RUN:  if (cfg_chg)        state_nx = LB_IDLE;
            default:                     state_nx = LB_IDLE;
        endcase
    end

    always_comb begin
        wr_en      = pix_valid && !cfg_chg;
        rows_ready = (state == LB_RUN);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            addr  <= '0;
            wraps <= '0;
        end else begin
            cfg_q <= {cfg_deep, cfg_last};
            if (cfg_chg) begin
                addr  <= '0;
                wraps <= '0;
            end else if (pix_valid) begin
                addr <= at_end ? '0 : addr + 1'b1;
                if (at_end && wraps != need) wraps <= wraps + 1'b1;
            end
        end
    end

    // R10
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_chg |-> addr <= eff_last);
    // R10
    addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && at_end) |=> addr == '0);
    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_valid && !cfg_chg) |=> $stable(addr));
    // R9
    cfg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |=> (state == LB_IDLE && addr == '0 && !rows_ready));
    // R8
    ready_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != LB_RUN && !(wr_en && at_end)) |=> state != LB_RUN);
endmodule

// File: rtl/line_delay_bank.sv
module line_delay_bank #(
    parameter int PIX_W   = 8,
    parameter int MAX_LEN = 256,
    parameter int BPG     = 4,
    localparam int AW     = $clog2(MAX_LEN),
    localparam int HALF   = MAX_LEN / 2,
    localparam int NB     = 2 * BPG
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pix_valid,
    input  logic [PIX_W-1:0]    pix_a,
    input  logic [PIX_W-1:0]    pix_b,
    input  logic                bypass_in,
    input  logic                cfg_deep,
    input  logic                cfg_force_byp,
    input  logic [AW-1:0]       cfg_last,
    output logic [NB*PIX_W-1:0] taps,
    output logic                rows_ready
);
    logic [AW-1:0]    addr;
    logic             wr_en;
    logic             byp;
    logic [NB-1:0]    bank_we;
    logic [PIX_W-1:0] bank_out [NB];
    logic [PIX_W-1:0] bank_din [NB];
    logic [PIX_W-1:0] line_out [NB];
    logic [PIX_W-1:0] tap_v    [NB];
    logic [PIX_W-1:0] stage_in [NB];

    assign byp = bypass_in | cfg_force_byp;

    lb_ctrl #(.AW(AW), .BPG(BPG)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_valid (pix_valid),
        .cfg_deep  (cfg_deep),
        .cfg_last  (cfg_last),
        .addr      (addr),
        .wr_en     (wr_en),
        .rows_ready(rows_ready)
    );

    for (genvar g = 0; g < 2; g++) begin : g_grp
        for (genvar k = 0; k < BPG; k++) begin : g_stage
            localparam int  S   = g * BPG + k;
            localparam bit  ODD = (k % 2) == 1;

            lb_bank #(.W(PIX_W), .DEPTH(HALF)) u_bank (
                .clk (clk),
                .we  (bank_we[S]),
                .addr(addr[AW-2:0]),
                .din (bank_din[S]),
                .dout(bank_out[S])
            );

            // in shallow mode bank pair (2m, 2m+1) forms stage m, split by address top bit
            assign bank_we[S]  = wr_en & (cfg_deep | (addr[AW-1] == ODD));
            assign bank_din[S] = cfg_deep ? stage_in[S] : stage_in[g*BPG + k/2];

            if (k < BPG / 2) begin : g_joined
                assign line_out[S] = cfg_deep ? bank_out[S]
                                   : (addr[AW-1] ? bank_out[g*BPG + 2*k + 1]
                                                 : bank_out[g*BPG + 2*k]);
            end else begin : g_solo
                assign line_out[S] = cfg_deep ? bank_out[S] : '0;
            end

            if (g == 1 && k == 0) begin : g_skip
                assign tap_v[S] = byp ? pix_b : line_out[S];
            end else begin : g_plain
                assign tap_v[S] = line_out[S];
            end

            if (k == 0) begin : g_head
                assign stage_in[S] = (g == 0) ? pix_a : pix_b;
            end else begin : g_chain
                assign stage_in[S] = tap_v[S-1];
            end

            assign taps[S*PIX_W +: PIX_W] = tap_v[S];
        end
    end

    // R4
    pair_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_deep |-> $onehot0(bank_we[1:0]));
endmodule

// File: tb/line_delay_bank_test.sv
`timescale 1ns/1ps
module line_delay_bank_test;
    localparam int PW  = 8;
    localparam int ML  = 256;
    localparam int BPG = 4;
    localparam int NB  = 2 * BPG;
    localparam int AW  = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          pix_valid;
    logic [PW-1:0] pix_a, pix_b;
    logic          bypass_in, cfg_deep, cfg_force_byp;
    logic [AW-1:0] cfg_last;
    logic [NB*PW-1:0] taps;
    logic          rows_ready;

    always #2 clk = ~clk;

    line_delay_bank #(.PIX_W(PW), .MAX_LEN(ML), .BPG(BPG)) uut (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_a(pix_a), .pix_b(pix_b),
        .bypass_in(bypass_in), .cfg_deep(cfg_deep), .cfg_force_byp(cfg_force_byp),
        .cfg_last(cfg_last), .taps(taps), .rows_ready(rows_ready)
    );

    int checks = 0, errors = 0;
    bit done = 0;
    int hin [NB][4096];
    bit vin [NB][4096];
    int exp_t [NB];
    bit exp_ok [NB];
    int n = 0, cur_len = 5, cur_lines = 2;
    bit cur_deep = 0;

    function automatic int len_of(bit deep, int last);
        return deep ? (last % (ML / 2)) + 1 : last + 1;
    endfunction

    task automatic check(string tag, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (n=%0d)", tag, act, expv, n);
        end
    endtask

    task automatic compute(bit store);
        for (int g = 0; g < 2; g++) begin
            for (int k = 0; k < BPG; k++) begin
                int s = g * BPG + k;
                int inv;
                bit inok;
                if (k >= cur_lines) begin
                    exp_t[s] = 0; exp_ok[s] = 1;
                    continue;
                end
                inv  = (k == 0) ? ((g == 0) ? int'(pix_a) : int'(pix_b)) : exp_t[s-1];
                inok = (k == 0) ? 1'b1 : exp_ok[s-1];
                if (store) begin
                    hin[s][n] = inv; vin[s][n] = inok;
                end
                if (g == 1 && k == 0 && (bypass_in || cfg_force_byp)) begin
                    exp_t[s] = int'(pix_b); exp_ok[s] = 1;
                end else if (n >= cur_len) begin
                    exp_t[s] = hin[s][n-cur_len]; exp_ok[s] = vin[s][n-cur_len];
                end else begin
                    exp_t[s] = 0; exp_ok[s] = 0;
                end
            end
        end
    endtask

    task automatic check_outputs(bit hold);
        for (int s = 0; s < NB; s++) begin
            string tag;
            int k = s % BPG;
            if (!exp_ok[s]) continue;
            if (k >= cur_lines)                          tag = "R4 unused tap";
            else if (s == BPG && cfg_force_byp)          tag = "R6 forced bypass";
            else if (s == BPG && bypass_in)              tag = "R5 bypass";
            else if (hold)                               tag = "R7 hold";
            else if (cur_deep)                           tag = "R3 deep tap";
            else                                         tag = "R2 shallow tap";
            check($sformatf("%s slot %0d", tag, s), int'(taps[s*PW +: PW]), exp_t[s]);
        end
        check("R8 rows_ready", int'(rows_ready), (n >= cur_lines * cur_len) ? 1 : 0);
    endtask

    task automatic pixel(bit v, int a, int b, bit byp);
        pix_valid = v; pix_a = a[PW-1:0]; pix_b = b[PW-1:0]; bypass_in = byp;
        #1;
        compute(v);
        check_outputs(!v);
        if (v) n++;
        @(negedge clk);
    endtask

    task automatic set_cfg(bit deep, int last);
        bit same = (deep == cfg_deep) && (last[AW-1:0] == cfg_last);
        pix_valid = 0;
        cfg_deep = deep; cfg_last = last[AW-1:0];
        @(negedge clk);
        if (!same) begin
            n = 0;
            check("R9 cleared after config change", int'(rows_ready), 0);
        end
        cur_deep = deep;
        cur_len = len_of(deep, last);
        cur_lines = deep ? BPG : BPG / 2;
    endtask

    task automatic run_seg(int count, int gap_pct, int tog_pct, bit byp0);
        bit byp = byp0;
        for (int i = 0; i < count; i++) begin
            if ($urandom_range(99) < tog_pct) byp = ~byp;
            if ($urandom_range(99) < gap_pct) pixel(0, $urandom, $urandom, byp);
            pixel(1, $urandom, $urandom, byp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 0; pix_valid = 0; pix_a = 0; pix_b = 0; bypass_in = 0;
        cfg_deep = 0; cfg_force_byp = 0; cfg_last = 8'd4;
        repeat (3) @(negedge clk);
        #1;
        check("R1 rows_ready in reset", int'(rows_ready), 0);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        @(negedge clk);
        check("R1 rows_ready after reset", int'(rows_ready), 0);

        // short shallow rows with idle gaps
        run_seg(40, 20, 0, 0);
        // longest shallow row
        set_cfg(0, 255);
        run_seg(560, 0, 0, 0);
        // deep mode with top bit set: length 0x43+1
        set_cfg(1, 8'hC3);
        run_seg(320, 10, 0, 0);
        // longest deep row
        set_cfg(1, 127);
        run_seg(540, 0, 0, 0);
        // single-pixel rows
        set_cfg(1, 0);
        run_seg(20, 30, 0, 0);
        // bypass toggling, deep rows of 7
        set_cfg(1, 6);
        run_seg(80, 10, 15, 1);
        // forced bypass with pin low
        cfg_force_byp = 1;
        run_seg(60, 10, 0, 0);
        cfg_force_byp = 0;
        // pixel offered in the config change cycle must be dropped (R9)
        set_cfg(0, 9);
        run_seg(30, 0, 0, 0);
        pix_valid = 1; pix_a = 8'h5A; pix_b = 8'hA5;
        cfg_deep = 0; cfg_last = 8'd3;
        @(negedge clk);
        n = 0; cur_len = 4; cur_lines = 2; cur_deep = 0;
        check("R9 dropped pixel cleared ready", int'(rows_ready), 0);
        run_seg(20, 0, 0, 0);

        for (int seg = 0; seg < 8; seg++) begin
            bit d = 1'($urandom_range(1));
            int ln = $urandom_range(40, 1);
            int last = ln - 1;
            if (d && $urandom_range(1) == 1) last = last + 128;
            set_cfg(d, last);
            cfg_force_byp = 1'($urandom_range(3) == 0);
            run_seg((d ? 4 : 2) * ln + 25, 15, 10, 1'($urandom_range(1)));
            cfg_force_byp = 0;
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule